// File: doc/BRIEF.md
# Register Rename Map with Recycled Tag Pool

This block translates the architectural register names of one instruction per cycle into physical tags for an out-of-order core that keeps all results in one tag-indexed register file. For each of two source operands it returns the physical tag that currently holds the value and whether that value has been produced yet. For an instruction that writes a register, it takes a fresh tag from a pool of unused tags and records it as the new home of that architectural register. It also reports the tag that was displaced, so the in-order completion queue can keep that tag with the instruction.

Result tags broadcast by the execution side mark values as produced. When an instruction graduates, its displaced tag is no longer reachable and returns to the pool. After a misprediction or exception, the completion queue replays its entries from youngest to oldest, one per cycle. Each step puts the displaced tag back into the map and returns the squashed instruction's own tag to the pool. Readiness is kept per physical tag rather than per map entry, so a restored mapping brings back the correct produced or pending status.

Top module: `rename_map_top`

## Requirements
- R1: After reset, architectural register i maps to tag i and every tag is ready. The pool holds tags 32 through 79, which are handed out in ascending order.
- R2: For each source, `src_x_tag` is the tag mapped to the named register at the start of the cycle and `src_x_rdy` is that tag's ready flag. A source that names the same register as the instruction's destination sees the old mapping.
- R3: `dst_tag` always shows the oldest tag in the pool. A rename that fires with a destination consumes this tag. From the next cycle the destination maps to it and it reads as not ready.
- R4: `dst_prev_tag` shows the tag mapped to `ren_dst` before any update in that cycle.
- R5: A broadcast on `wb_valid`/`wb_tag` sets that tag's ready flag from the next cycle. A source whose looked-up tag equals the tag broadcast in the same cycle is reported ready in that cycle.
- R6: `ren_stall` is high when `ren_valid` is high and either a rollback step is present, or the instruction has a destination and the pool is empty. A stalled rename changes no mapping and takes no tag. A rename without a destination does not take a tag and is not held back by an empty pool.
- R7: A graduation (`grad_valid`) appends `grad_tag` to the tail of the pool. A tag returned while the pool is empty becomes available in the following cycle, not the same one.
- R8: A rollback step (`rb_valid`) sets the mapping of `rb_arch` to `rb_prev_tag` from the next cycle and appends `rb_new_tag` to the pool. If a graduation happens in the same cycle, the graduating tag goes in first.
- R9: A rollback step does not alter any ready flag. The restored tag reads ready exactly when it had been broadcast before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst | input | 5 | Destination architectural register |
| src_a_tag | output | 7 | Physical tag of first source |
| src_a_rdy | output | 1 | First source value produced |
| src_b_tag | output | 7 | Physical tag of second source |
| src_b_rdy | output | 1 | Second source value produced |
| dst_tag | output | 7 | Tag assigned to the destination (pool head) |
| dst_prev_tag | output | 7 | Tag displaced from the destination |
| ren_stall | output | 1 | Rename not accepted this cycle |
| wb_valid | input | 1 | A result tag is broadcast |
| wb_tag | input | 7 | Broadcast result tag |
| grad_valid | input | 1 | An instruction graduates |
| grad_tag | input | 7 | Displaced tag freed by graduation |
| rb_valid | input | 1 | One rollback step is applied |
| rb_arch | input | 5 | Architectural register being restored |
| rb_prev_tag | input | 7 | Tag to map back into `rb_arch` |
| rb_new_tag | input | 7 | Squashed instruction's tag, returned to the pool |

## Verification
Two pairs of events can meet in one cycle. A source lookup can coincide with a broadcast of the very tag it resolves to. A graduation can coincide with a rollback step, so two tags enter the pool at once. The bench provokes the first case by broadcasting a freshly allocated tag while a source names its register. It provokes the second by graduating the oldest in-flight record while rolling back the youngest. A behavioural model with a tag queue and integer arrays judges every cycle. It checks the same-cycle ready bypass and the order of the two returned tags, which later allocations reveal on `dst_tag`. A graduation into an empty pool alongside a rename with a destination is also driven, to confirm the rename stalls for that cycle.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    parameter int unsigned ARCH_REGS_DEF = 32;
    parameter int unsigned PHYS_REGS_DEF = 80;
    parameter int unsigned NUM_SRC       = 2;

    // Wrapping increment for a circular index of arbitrary depth.
    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
    parameter int unsigned TAG_W     = 7,
    parameter int unsigned DEPTH     = 48,
    parameter int unsigned FIRST_TAG = 32,
    parameter int unsigned PW        = $clog2(DEPTH),
    parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push0_en,
    input  logic [TAG_W-1:0] push0_tag,
    input  logic             push1_en,
    input  logic [TAG_W-1:0] push1_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty
);
    import rnm_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] slot;
        logic [PW-1:0]               rd;
        logic [PW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fl_state_t;

    function automatic fl_state_t reset_state();
        fl_state_t s;
        for (int k = 0; k < DEPTH; k++) begin
            s.slot[k] = TAG_W'(FIRST_TAG + k);
        end
        s.rd  = '0;
        s.wr  = '0;
        s.cnt = CW'(DEPTH);
        return s;
    endfunction

    localparam fl_state_t RST_STATE = reset_state();

    fl_state_t state_d, state_q;

    always_comb begin
        logic [PW-1:0] wp;
        logic [CW-1:0] c;
        state_d = state_q;
        wp      = state_q.wr;
        c       = state_q.cnt;
        if (pop) begin
            state_d.rd = PW'(wrap_inc(int'(state_q.rd), DEPTH));
            c          = c - 1'b1;
        end
        if (push0_en) begin
            state_d.slot[wp] = push0_tag;
            wp               = PW'(wrap_inc(int'(wp), DEPTH));
            c                = c + 1'b1;
        end
        if (push1_en) begin
            state_d.slot[wp] = push1_tag;
            wp               = PW'(wrap_inc(int'(wp), DEPTH));
            c                = c + 1'b1;
        end
        state_d.wr  = wp;
        state_d.cnt = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign head_tag = state_q.slot[state_q.rd];
    assign empty    = (state_q.cnt == '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (state_q.cnt != '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(state_q.cnt) + int'(push0_en) + int'(push1_en) - int'(pop)) <= int'(DEPTH));

    // R3
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push0_en && !push1_en) |=> (state_q.cnt == $past(state_q.cnt) - 1'b1));

endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
    parameter int unsigned ARCH_REGS = 32,
    parameter int unsigned PHYS_REGS = 80,
    parameter int unsigned NSRC      = 2,
    parameter int unsigned AREG_W    = $clog2(ARCH_REGS),
    parameter int unsigned TAG_W     = $clog2(PHYS_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0][AREG_W-1:0]   src_arch,
    output logic [NSRC-1:0][TAG_W-1:0]    src_tag,
    output logic [NSRC-1:0]               src_rdy,
    input  logic [AREG_W-1:0]             dst_arch,
    output logic [TAG_W-1:0]              dst_prev,
    input  logic                          alloc_en,
    input  logic [TAG_W-1:0]              alloc_tag,
    input  logic                          wb_valid,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic                          rb_en,
    input  logic [AREG_W-1:0]             rb_arch,
    input  logic [TAG_W-1:0]              rb_tag
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(PHYS_REGS - 1);

    typedef struct packed {
        logic [ARCH_REGS-1:0][TAG_W-1:0] map;
        logic [PHYS_REGS-1:0]            rdy;
    } mt_state_t;

    function automatic mt_state_t reset_state();
        mt_state_t s;
        for (int i = 0; i < ARCH_REGS; i++) begin
            s.map[i] = TAG_W'(i);
        end
        s.rdy = '1;
        return s;
    endfunction

    localparam mt_state_t RST_STATE = reset_state();

    mt_state_t state_d, state_q;

    logic wb_in_range;
    assign wb_in_range = wb_valid && (wb_tag <= LAST_TAG);

    always_comb begin
        state_d = state_q;
        if (wb_in_range) begin
            state_d.rdy[wb_tag] = 1'b1;
        end
        if (alloc_en) begin
            state_d.map[dst_arch] = alloc_tag;
            state_d.rdy[alloc_tag] = 1'b0;
        end
        if (rb_en) begin
            state_d.map[rb_arch] = rb_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [TAG_W-1:0] t;
        assign t          = state_q.map[src_arch[g]];
        assign src_tag[g] = t;
        assign src_rdy[g] = state_q.rdy[t] | (wb_in_range && (wb_tag == t));
    end

    assign dst_prev = state_q.map[dst_arch];

    // R3
    alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> !state_q.rdy[$past(alloc_tag)]);

    // R3
    alloc_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !rb_en) |=> (state_q.map[$past(dst_arch)] == $past(alloc_tag)));

    // R5
    wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_in_range && !(alloc_en && alloc_tag == wb_tag)) |=> state_q.rdy[$past(wb_tag)]);

    // R8
    rb_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_en |=> (state_q.map[$past(rb_arch)] == $past(rb_tag)));

    // R9
    rb_rdy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_en && !alloc_en && !wb_valid) |=> $stable(state_q.rdy));

endmodule

// File: rtl/rename_map_top.sv
module rename_map_top #(
    parameter int unsigned ARCH_REGS = rnm_pkg::ARCH_REGS_DEF,
    parameter int unsigned PHYS_REGS = rnm_pkg::PHYS_REGS_DEF,
    parameter int unsigned AREG_W    = $clog2(ARCH_REGS),
    parameter int unsigned TAG_W     = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [AREG_W-1:0] ren_src_a,
    input  logic [AREG_W-1:0] ren_src_b,
    input  logic              ren_has_dst,
    input  logic [AREG_W-1:0] ren_dst,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_a_rdy,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic              src_b_rdy,
    output logic [TAG_W-1:0]  dst_tag,
    output logic [TAG_W-1:0]  dst_prev_tag,
    output logic              ren_stall,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic              grad_valid,
    input  logic [TAG_W-1:0]  grad_tag,
    input  logic              rb_valid,
    input  logic [AREG_W-1:0] rb_arch,
    input  logic [TAG_W-1:0]  rb_prev_tag,
    input  logic [TAG_W-1:0]  rb_new_tag
);
    import rnm_pkg::*;

    localparam int unsigned FREE_DEPTH = PHYS_REGS - ARCH_REGS;

    logic                        pool_empty;
    logic [TAG_W-1:0]            pool_head;
    logic                        fire;
    logic                        alloc;
    logic [NUM_SRC-1:0][AREG_W-1:0] src_vec;
    logic [NUM_SRC-1:0][TAG_W-1:0]  tag_vec;
    logic [NUM_SRC-1:0]             rdy_vec;

    assign ren_stall = ren_valid && (rb_valid || (ren_has_dst && pool_empty));
    assign fire      = ren_valid && !ren_stall;
    assign alloc     = fire && ren_has_dst;

    assign src_vec[0] = ren_src_a;
    assign src_vec[1] = ren_src_b;
    assign src_a_tag  = tag_vec[0];
    assign src_b_tag  = tag_vec[1];
    assign src_a_rdy  = rdy_vec[0];
    assign src_b_rdy  = rdy_vec[1];
    assign dst_tag    = pool_head;

    rnm_free_list #(
        .TAG_W     (TAG_W),
        .DEPTH     (FREE_DEPTH),
        .FIRST_TAG (ARCH_REGS)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc),
        .push0_en  (grad_valid),
        .push0_tag (grad_tag),
        .push1_en  (rb_valid),
        .push1_tag (rb_new_tag),
        .head_tag  (pool_head),
        .empty     (pool_empty)
    );

    rnm_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .NSRC      (NUM_SRC),
        .AREG_W    (AREG_W),
        .TAG_W     (TAG_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_arch  (src_vec),
        .src_tag   (tag_vec),
        .src_rdy   (rdy_vec),
        .dst_arch  (ren_dst),
        .dst_prev  (dst_prev_tag),
        .alloc_en  (alloc),
        .alloc_tag (pool_head),
        .wb_valid  (wb_valid),
        .wb_tag    (wb_tag),
        .rb_en     (rb_valid),
        .rb_arch   (rb_arch),
        .rb_tag    (rb_prev_tag)
    );

    // R6
    stall_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_stall && !grad_valid && !rb_valid) |=> $stable(dst_tag));

endmodule

// File: tb/rename_map_top_tb_top.sv
module rename_map_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rv = 1'b0;
    logic [4:0] s_a = '0, s_b = '0, dreg = '0, rba = '0;
    logic       hd = 1'b0, wbv = 1'b0, gv = 1'b0, rbv = 1'b0;
    logic [6:0] wbt = '0, gt = '0, rbp = '0, rbn = '0;

    logic [6:0] src_a_tag, src_b_tag, dst_tag, dst_prev_tag;
    logic       src_a_rdy, src_b_rdy, ren_stall;

    int checks = 0;
    int fails  = 0;
    string focus = "";

    int mmap [32];
    bit mrdy [80];
    int fq [$];
    int rec_arch [$];
    int rec_prev [$];
    int rec_new  [$];

    always #5 clk = ~clk;

    rename_map_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(rv), .ren_src_a(s_a), .ren_src_b(s_b),
        .ren_has_dst(hd), .ren_dst(dreg),
        .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy),
        .src_b_tag(src_b_tag), .src_b_rdy(src_b_rdy),
        .dst_tag(dst_tag), .dst_prev_tag(dst_prev_tag), .ren_stall(ren_stall),
        .wb_valid(wbv), .wb_tag(wbt),
        .grad_valid(gv), .grad_tag(gt),
        .rb_valid(rbv), .rb_arch(rba), .rb_prev_tag(rbp), .rb_new_tag(rbn)
    );

    function automatic string lbl(input string dflt);
        return (focus != "") ? focus : dflt;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        rv = 0; hd = 0; wbv = 0; gv = 0; rbv = 0;
    endtask

    // Compare one cycle against the model, then advance the model.
    task automatic step();
        int t1, t2, nt;
        bit e1, e2, st;
        #1;
        t1 = mmap[s_a];
        t2 = mmap[s_b];
        e1 = mrdy[t1] || (wbv && int'(wbt) == t1);
        e2 = mrdy[t2] || (wbv && int'(wbt) == t2);
        st = rv && (rbv || (hd && fq.size() == 0));
        chk(int'(src_a_tag) == t1, lbl("R2"), "src_a_tag", int'(src_a_tag), t1);
        chk(int'(src_b_tag) == t2, lbl("R2"), "src_b_tag", int'(src_b_tag), t2);
        chk(src_a_rdy == e1, lbl((wbv && int'(wbt) == t1) ? "R5" : "R2"), "src_a_rdy", int'(src_a_rdy), int'(e1));
        chk(src_b_rdy == e2, lbl((wbv && int'(wbt) == t2) ? "R5" : "R2"), "src_b_rdy", int'(src_b_rdy), int'(e2));
        chk(int'(dst_prev_tag) == mmap[dreg], lbl("R4"), "dst_prev_tag", int'(dst_prev_tag), mmap[dreg]);
        chk(ren_stall == st, lbl("R6"), "ren_stall", int'(ren_stall), int'(st));
        if (fq.size() > 0) begin
            chk(int'(dst_tag) == fq[0], lbl("R3"), "dst_tag", int'(dst_tag), fq[0]);
        end
        if (wbv) mrdy[wbt] = 1;
        if (rv && !st && hd) begin
            nt = fq.pop_front();
            rec_arch.push_back(int'(dreg));
            rec_prev.push_back(mmap[dreg]);
            rec_new.push_back(nt);
            mmap[dreg] = nt;
            mrdy[nt] = 0;
        end
        if (gv) fq.push_back(int'(gt));
        if (rbv) begin
            mmap[rba] = int'(rbp);
            fq.push_back(int'(rbn));
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic ren(input int a, input int b, input bit h, input int d);
        rv = 1; s_a = 5'(a); s_b = 5'(b); hd = h; dreg = 5'(d);
        step();
    endtask

    task automatic look(input int a, input int b);
        s_a = 5'(a); s_b = 5'(b);
        step();
    endtask

    // Load graduation of the oldest record onto the inputs.
    task automatic set_grad();
        void'(rec_arch.pop_front());
        void'(rec_new.pop_front());
        gv = 1; gt = 7'(rec_prev.pop_front());
    endtask

    // Load rollback of the youngest record onto the inputs.
    task automatic set_rb();
        rbv = 1;
        rba = 5'(rec_arch.pop_back());
        rbp = 7'(rec_prev.pop_back());
        rbn = 7'(rec_new.pop_back());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("[TB] FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int a9, b9;
        for (int i = 0; i < 32; i++) mmap[i] = i;
        for (int i = 0; i < 80; i++) mrdy[i] = 1;
        for (int i = 32; i < 80; i++) fq.push_back(i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: identity mapping, all ready, pool head is 32
        focus = "R1";
        for (int i = 0; i < 32; i++) look(i, 31 - i);
        focus = "";

        // R2 R3 R4: basic renames
        ren(2, 3, 1, 1);
        focus = "R2";
        ren(1, 1, 1, 1);          // source equals destination: old mapping
        focus = "";
        ren(1, 4, 0, 0);          // no destination: no tag consumed
        look(1, 2);

        // R5: broadcast coincides with lookup, then persists
        focus = "R5";
        wbv = 1; wbt = 7'(rec_new[rec_new.size() - 1]);
        look(1, 3);
        look(1, 3);
        focus = "";

        // Exhaust the pool
        for (int k = 0; fq.size() > 0; k++) ren(k % 32, (k + 7) % 32, 1, (k * 5) % 32);

        // R6: stalls on empty pool; rename without destination still fires
        focus = "R6";
        ren(5, 6, 1, 7);
        ren(7, 8, 1, 7);
        ren(5, 6, 0, 0);
        look(7, 7);
        focus = "";

        // R7: graduation into empty pool with a rename: stall this cycle
        focus = "R7";
        set_grad();
        rv = 1; s_a = 5'd3; s_b = 5'd4; hd = 1; dreg = 5'd12;
        step();
        ren(12, 3, 1, 12);        // gets the graduated tag
        for (int k = 0; k < 3; k++) begin
            set_grad();
            step();
        end
        focus = "";

        // R8: rollback steps, youngest first, with a rename attempted
        focus = "R8";
        for (int k = 0; k < 4; k++) begin
            a9 = rec_arch[rec_arch.size() - 1];
            set_rb();
            rv = 1; hd = 1; dreg = 5'd20; s_a = 5'(a9); s_b = 5'(a9);
            step();
            look(a9, 20);
        end
        focus = "";

        // R9: restored tag brings back its own ready status
        focus = "R9";
        ren(0, 0, 1, 9);
        a9 = rec_new[rec_new.size() - 1];
        ren(9, 9, 1, 9);
        wbv = 1; wbt = 7'(a9);
        look(9, 0);
        set_rb();
        step();
        look(9, 9);               // restored tag, broadcast before: ready
        ren(0, 0, 1, 10);
        b9 = rec_new[rec_new.size() - 1];
        ren(10, 10, 1, 10);
        set_rb();
        step();
        look(10, 10);             // restored tag never broadcast: not ready
        chk(b9 >= 0, "R9", "restored tag index", b9, b9);
        focus = "";

        // R8: graduation and rollback in one cycle, order seen on dst_tag
        focus = "R8";
        set_grad();
        set_rb();
        step();
        for (int k = 0; k < 4; k++) ren(k, k + 1, 1, 20 + k);
        focus = "";

        // Drain remaining pool order
        focus = "R3";
        for (int k = 0; k < 6; k++) ren(k + 8, k, 1, k + 8);
        focus = "";

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule